// File: doc/BRIEF.md
# Page-Aligned EEPROM Write Burst Splitter

This block sits between a host that wants to store an arbitrary run of bytes and a byte-level write engine for a page-organised EEPROM. The device latches a page address at the start of each write transaction. Data that runs past the end of a page wraps back to the start of that same page and overwrites bytes already loaded. The splitter accepts one request at a time, made of a start address and a byte count, followed by a stream of data bytes. It cuts the request into bursts so that no burst ever runs past the end of a page.

Each burst goes to the engine as a START command carrying the burst's address, then one DATA command per byte, then a STOP command. The device then runs its internal write cycle and holds its busy flag high. The splitter does not begin the next burst until that flag is low. An unaligned start gives a short first burst that runs up to the next page edge. Full, page-aligned bursts follow, and a short last burst takes whatever bytes remain. A single-cycle `done` pulse marks the end of the final write cycle.

The request, input byte and command interfaces all use valid/ready. A transfer happens on a rising edge where both valid and ready are high. A command, once offered, stays offered with the same kind and address until it is taken. During a data phase each input byte passes straight through to the command port in the same cycle, so the engine's `cmd_ready` is the back-pressure on the byte source. `in_ready` is low at all other times.

Top module: `page_burst_splitter`

## Requirements
- R1: `req_ready` is high exactly when no request is in progress. A request is accepted on a rising edge with `req_valid` and `req_ready` both high, and `req_addr`/`req_len` are taken from that edge.
- R2: Commands use `cmd_kind` codes START=0, DATA=1 and STOP=2. Every burst is one START, then its data bytes as DATA commands, then one STOP. The DATA commands carry the input bytes in stream order on `cmd_data`. No command is offered while idle.
- R3: No burst holds more than PAGE_BYTES bytes, and no burst runs from one page into the next.
- R4: The first burst holds min(PAGE_BYTES − (address mod PAGE_BYTES), length) bytes.
- R5: Every burst after the first starts on a page boundary. Each such burst holds min(PAGE_BYTES, remaining) bytes, so an aligned address with an aligned length gives only full bursts.
- R6: The `cmd_addr` of each START equals the request address plus the number of bytes already sent in this request, modulo 2^ADDR_W.
- R7: Once a STOP is accepted, no START is offered until `dev_busy` has been sampled low. The device must raise `dev_busy` by the cycle after STOP acceptance if it intends to raise it at all.
- R8: A zero-length request produces no commands and no byte transfers. `done` pulses in the cycle after its acceptance.
- R9: For a non-empty request, `done` is high for exactly one cycle. That cycle is the one after `dev_busy` is first sampled low following the final STOP. `done` is low at all other times.
- R10: A START or STOP that is offered but not accepted stays offered with the same kind and address in the next cycle. `in_ready` is high only while a DATA command is being offered to an engine that is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Splitter idle, request can be taken |
| req_addr | input | ADDR_W | Start byte address of the request |
| req_len | input | LEN_W | Number of bytes in the request |
| in_valid | input | 1 | Input byte offered |
| in_ready | output | 1 | Input byte taken this cycle |
| in_data | input | 8 | Input byte |
| cmd_valid | output | 1 | Command offered to the write engine |
| cmd_ready | input | 1 | Write engine takes the command |
| cmd_kind | output | 2 | 0 START, 1 DATA, 2 STOP |
| cmd_addr | output | ADDR_W | Burst address, meaningful with START |
| cmd_data | output | 8 | Data byte, meaningful with DATA |
| dev_busy | input | 1 | Device internal write cycle running |
| done | output | 1 | One-cycle pulse when the request is complete |

## Verification
The bench builds the splitter with an 8-byte page and a 6-bit address space. With those values, a sweep of every start offset across three pages, paired with every length from 0 to 27, is only a few hundred requests. That sweep yields no bursts, single short bursts, bursts that end exactly on a page edge, runs of full pages, and short bursts at both ends. Starts in the last page add address wrap-around of the whole space. Pseudo-random stalls on the input and command handshakes, and device busy times from zero to three cycles, exercise the back-pressure rules, the busy wait and the exact `done` timing.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  typedef enum logic [1:0] {
    CMD_START = 2'd0,
    CMD_DATA  = 2'd1,
    CMD_STOP  = 2'd2
  } pbs_cmd_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_STOP,
    S_WAIT
  } pbs_state_e;
endpackage

// File: rtl/pbs_chunk_calc.sv
// Length of the burst that may start at a given address: the room left in
// the current page, capped by the bytes still owed to the request.
module pbs_chunk_calc #(
  parameter int ADDR_W     = 14,
  parameter int LEN_W      = 15,
  parameter int PAGE_BYTES = 64
) (
  input  logic [ADDR_W-1:0]               addr,
  input  logic [LEN_W-1:0]                remaining,
  output logic [$clog2(PAGE_BYTES):0]     chunk_len
);
  localparam int OFF_W = $clog2(PAGE_BYTES);

  logic [OFF_W-1:0] offset;
  logic [OFF_W:0]   room;

  always_comb begin
    offset = addr[OFF_W-1:0];
    room   = (OFF_W+1)'(PAGE_BYTES) - {1'b0, offset};
    if (remaining < LEN_W'(room))
      chunk_len = remaining[OFF_W:0];
    else
      chunk_len = room;
  end
endmodule

// File: rtl/pbs_seq.sv
// Burst sequencer: START / DATA... / STOP per burst, then wait out busy.
module pbs_seq
  import pbs_pkg::*;
#(
  parameter int ADDR_W     = 14,
  parameter int LEN_W      = 15,
  parameter int PAGE_BYTES = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [LEN_W-1:0]              req_len,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [7:0]                    in_data,
  output logic                          cmd_valid,
  input  logic                          cmd_ready,
  output logic [1:0]                    cmd_kind,
  output logic [ADDR_W-1:0]             cmd_addr,
  output logic [7:0]                    cmd_data,
  input  logic                          dev_busy,
  output logic                          done,
  output logic [ADDR_W-1:0]             cur_addr,
  output logic [LEN_W-1:0]              remaining,
  input  logic [$clog2(PAGE_BYTES):0]   chunk_len
);
  localparam int OFF_W = $clog2(PAGE_BYTES);

  pbs_state_e     state;
  logic [OFF_W:0] burst_left;
  logic           byte_xfer;

  assign byte_xfer = (state == S_DATA) && in_valid && cmd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cur_addr   <= '0;
      remaining  <= '0;
      burst_left <= '0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          if (req_len == '0) begin
            done <= 1'b1;
          end else begin
            cur_addr  <= req_addr;
            remaining <= req_len;
            state     <= S_START;
          end
        end
        S_START: if (cmd_ready) begin
          burst_left <= chunk_len;
          state      <= S_DATA;
        end
        S_DATA: if (byte_xfer) begin
          cur_addr   <= cur_addr + ADDR_W'(1);
          remaining  <= remaining - LEN_W'(1);
          burst_left <= burst_left - (OFF_W+1)'(1);
          if (burst_left == (OFF_W+1)'(1)) state <= S_STOP;
        end
        S_STOP: if (cmd_ready) state <= S_WAIT;
        S_WAIT: if (!dev_busy) begin
          if (remaining == '0) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            state <= S_START;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready = (state == S_IDLE);
    in_ready  = byte_xfer;
    cmd_addr  = cur_addr;
    cmd_data  = in_data;
    case (state)
      S_START: begin cmd_valid = 1'b1;     cmd_kind = CMD_START; end
      S_DATA:  begin cmd_valid = in_valid; cmd_kind = CMD_DATA;  end
      S_STOP:  begin cmd_valid = 1'b1;     cmd_kind = CMD_STOP;  end
      default: begin cmd_valid = 1'b0;     cmd_kind = CMD_START; end
    endcase
  end

  // R3: a live burst is never empty and never larger than one page
  a_r3_burst_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DATA) |-> (burst_left != '0 && burst_left <= (OFF_W+1)'(PAGE_BYTES)));

  // R3: a burst that continues after this byte must not step into the next page
  a_r3_stays_in_page: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_xfer && burst_left != (OFF_W+1)'(1)) |-> (cur_addr[OFF_W-1:0] != {OFF_W{1'b1}}));

  // R10: an unaccepted START or STOP is held steady
  a_r10_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && cmd_kind != CMD_DATA) |=>
      (cmd_valid && $stable(cmd_kind) && $stable(cmd_addr)));

  // R7: busy keeps the sequencer waiting
  a_r7_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT && dev_busy) |=> (state == S_WAIT));

  // R9: done never lasts two cycles
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: empty request completes at once and stays idle
  a_r8_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_len == '0) |=> (done && req_ready && !cmd_valid));
endmodule

// File: rtl/page_burst_splitter.sv
module page_burst_splitter #(
  parameter int ADDR_W     = 14,
  parameter int LEN_W      = 15,
  parameter int PAGE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_kind,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [7:0]        cmd_data,
  input  logic              dev_busy,
  output logic              done
);
  localparam int OFF_W = $clog2(PAGE_BYTES);

  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  remaining;
  logic [OFF_W:0]    chunk_len;

  pbs_chunk_calc #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)
  ) u_chunk (
    .addr(cur_addr), .remaining(remaining), .chunk_len(chunk_len)
  );

  pbs_seq #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .dev_busy(dev_busy), .done(done),
    .cur_addr(cur_addr), .remaining(remaining), .chunk_len(chunk_len)
  );
endmodule

// File: tb/page_burst_splitter_bench.sv
module page_burst_splitter_bench;
  localparam int ADDR_W = 6;
  localparam int LEN_W  = 6;
  localparam int PAGE   = 8;
  localparam int ASPACE = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [7:0]        in_data = '0;
  logic              cmd_valid;
  logic              cmd_ready = 1'b0;
  logic [1:0]        cmd_kind;
  logic [ADDR_W-1:0] cmd_addr;
  logic [7:0]        cmd_data;
  logic              dev_busy = 1'b0;
  logic              done;

  page_burst_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE)) u_page_burst_splitter (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .dev_busy(dev_busy), .done(done)
  );

  always #2.5 clk = ~clk;

  int vectors = 0, fails = 0, cyc = 0;
  logic [15:0] lfsr = 16'hACE1;
  int want_req = 0, active = 0, phase = 0, got_done = 0;
  int exp_addr = 0, exp_rem = 0, burst_left = 0, nbursts = 0;
  int busy_cnt = 0, final_wait = 0, done_due = 0, next_due = 0;
  int in_idx = 0, out_idx = 0;
  int prev_stall = 0, prev_kind = 0, prev_addr = 0;

  function automatic logic [7:0] byte_of(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    if (cyc > 190000) begin
      chk(1'b0, "watchdog", cyc, 190000);
      finish_run();
    end
    lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    cmd_ready = lfsr[0] | lfsr[1];
    in_valid  = lfsr[2] | lfsr[3];
    in_data   = byte_of(in_idx);
    req_valid = (want_req != 0);
    if (busy_cnt > 0) begin dev_busy = 1'b1; busy_cnt--; end
    else dev_busy = 1'b0;
    #1;
    next_due = 0;
    // R8 R9: done exactly when due
    chk(done == (done_due != 0), "R9 R8 done timing", int'(done), done_due);
    if (done) begin active = 0; got_done = 1; end
    if (final_wait != 0 && !dev_busy) begin final_wait = 0; next_due = 1; end
    // R1: ready iff idle
    chk(req_ready == (active == 0), "R1 req_ready", int'(req_ready), int'(active == 0));
    // R2: no command while idle
    if (active == 0) chk(!cmd_valid, "R2 idle command", int'(cmd_valid), 0);
    // R10: held command
    if (prev_stall != 0)
      chk(cmd_valid && int'(cmd_kind) == prev_kind && int'(cmd_addr) == prev_addr,
          "R10 held command", int'(cmd_kind), prev_kind);
    // R10: input bytes only move with a DATA transfer
    if (in_valid && in_ready)
      chk(cmd_valid && cmd_kind == 2'd1 && cmd_ready, "R10 in_ready outside data", int'(cmd_kind), 1);
    if (req_valid && req_ready) begin
      want_req = 0;
      if (req_len == '0) next_due = 1;
      else begin
        active = 1; exp_addr = int'(req_addr); exp_rem = int'(req_len); phase = 0;
      end
    end
    if (cmd_valid && cmd_ready) begin
      case (cmd_kind)
        2'd0: begin
          chk(phase == 0 && exp_rem > 0, "R2 START order", phase, 0);
          chk(int'(cmd_addr) == exp_addr, "R6 burst address", int'(cmd_addr), exp_addr);
          chk(!dev_busy && busy_cnt == 0, "R7 START while busy", int'(dev_busy), 0);
          burst_left = PAGE - (exp_addr % PAGE);
          if (exp_rem < burst_left) burst_left = exp_rem;
          phase = 1;
        end
        2'd1: begin
          chk(phase == 1, "R3 R4 R5 DATA beyond burst", phase, 1);
          chk(cmd_data == byte_of(out_idx), "R2 data byte", int'(cmd_data), int'(byte_of(out_idx)));
          out_idx++;
          exp_addr = (exp_addr + 1) % ASPACE;
          exp_rem--; burst_left--;
          if (burst_left == 0) phase = 2;
        end
        default: begin
          chk(phase == 2, "R3 R4 R5 burst length at STOP", phase, 2);
          phase = 0;
          busy_cnt = nbursts % 4;
          nbursts++;
          if (exp_rem == 0) final_wait = 1;
        end
      endcase
    end
    if (in_valid && in_ready) in_idx++;
    prev_stall = (cmd_valid && !cmd_ready && cmd_kind != 2'd1) ? 1 : 0;
    prev_kind  = int'(cmd_kind);
    prev_addr  = int'(cmd_addr);
    done_due   = next_due;
  endtask

  task automatic run_req(input int a, input int l);
    req_addr = ADDR_W'(a);
    req_len  = LEN_W'(l);
    want_req = 1;
    got_done = 0;
    for (int t = 0; t < 3000 && got_done == 0; t++) step();
    chk(got_done != 0, "R9 request completes", got_done, 1);
    step();
    step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(req_ready, "R1 reset ready", int'(req_ready), 1);
    chk(!cmd_valid, "R2 reset no command", int'(cmd_valid), 0);
    chk(!done && !in_ready, "R9 reset done low", int'(done), 0);
    for (int a = 0; a < 3 * PAGE; a++)
      for (int l = 0; l < 28; l++)
        run_req(a, l);
    for (int a = ASPACE - PAGE; a < ASPACE; a++) run_req(a, 19);
    run_req(0, 4 * PAGE);
    run_req(PAGE, 0);
    finish_run();
  end
endmodule